// File: doc/BRIEF.md
# Charge Current Advertisement and Load Detect

This block sets the charging current that a power-source port offers to an attached sink and picks the current-limit setting for the VBUS switch. Two static configuration inputs select one of three advertisement levels: Default, 1.5 A and 3 A. The advertisement code and the limit select follow these inputs combinationally.

In the 3 A level the block also watches a digitised sample of the port output current, given in milliamps, and raises an active-low heavy-load flag when the draw stays above a threshold. A hysteresis band and a sample-count deglitch filter keep the flag from chattering. The flag is registered, so two ports can be wired in a cross pattern. Each port's flag then drives the other port's high-level configuration input. A port that carries a heavy load demotes its partner to 1.5 A, and the partner returns to 3 A once that load goes away.

Top module: `chg_adv_ldet`

## Requirements
- R1: With `cfg_en`=0 the advertisement `adv_code` is 2'b00 (Default), whatever the value of `cfg_hi`.
- R2: With `cfg_en`=1, `adv_code` is 2'b01 (1.5 A) when `cfg_hi`=0 and 2'b10 (3 A) when `cfg_hi`=1. The value 2'b11 never appears.
- R3: `ilim_sel` is 0 (the 1.7 A limit) for codes 2'b00 and 2'b01, and 1 (the 3.4 A limit) for code 2'b10.
- R4: Load detection is armed only when `cfg_en`=`cfg_hi`=1. At any clock edge where the block is not armed, `ld_n` goes high and the deglitch count is cleared.
- R5: While the flag is inactive, a sample counts as over when it is strictly greater than `THR_MA` (default 1950).
- R6: While the flag is active, a sample counts as over when it is greater than `THR_MA-HYST_MA` (default 1900). A sample at or below that level counts toward release.
- R7: The flag changes state only at the clock edge of the `DEB`-th consecutive valid sample (default 4) whose over/not-over result differs from the current flag. A valid sample that agrees with the flag restarts the count.
- R8: Cycles with `i_vld`=0 neither advance nor clear the count, and they leave `ld_n` unchanged.
- R9: `ld_n` is active low, comes from a register, and is high during reset and after reset.
- R10: When two ports are cross-wired (each `ld_n` driving the other's `cfg_hi`, both `cfg_en`=1), a heavy load on one port switches the other to code 2'b01. The other port returns to 2'b10 after the load clears, and the demoted port raises no flag of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Charging level enable (0 selects Default) |
| cfg_hi | input | 1 | High level request (3 A when set with cfg_en) |
| i_ma | input | IW (13) | Output current sample in milliamps |
| i_vld | input | 1 | Qualifies i_ma for one cycle |
| adv_code | output | 2 | Advertisement: 00 Default, 01 1.5 A, 10 3 A |
| ilim_sel | output | 1 | Current limit select: 0 = 1.7 A, 1 = 3.4 A |
| ld_n | output | 1 | Heavy-load flag, active low |

## Verification
All four configuration pairs are swept, with the current staying under the threshold, so the checks isolate the decoding of the code and the limit. Directed current sequences then probe the edges of the comparison. These sequences place samples exactly at the assert and release thresholds and one milliamp away from them. They also hold the count one sample short of `DEB` and then send an agreeing sample, insert gaps with no valid sample, and disarm the block while the flag is active. These cases separate a correct hysteresis band from a single-threshold compare, and a consecutive-sample filter from a total count. Random current samples clustered around the band, with random configuration and valid gaps, are compared against a bench model. A cross-wired pair confirms that the demotion happens and is later undone.

// File: rtl/chg_adv_pkg.sv
package chg_adv_pkg;

  typedef enum logic [1:0] {
    ADV_DEFAULT = 2'b00,
    ADV_MID     = 2'b01,
    ADV_HIGH    = 2'b10
  } adv_t;

  // Advertisement level from the two configuration inputs
  function automatic adv_t adv_decode(input logic en, input logic hi);
    if (!en)     return ADV_DEFAULT;
    else if (hi) return ADV_HIGH;
    else         return ADV_MID;
  endfunction

  // High limit only for the top advertisement
  function automatic logic ilim_is_high(input adv_t a);
    return (a == ADV_HIGH);
  endfunction

endpackage

// File: rtl/chg_adv_decode.sv
module chg_adv_decode
  import chg_adv_pkg::*;
(
  input  logic       cfg_en,
  input  logic       cfg_hi,
  output adv_t       adv,
  output logic       ilim_hi,
  output logic       armed
);
  always_comb begin
    adv     = adv_decode(cfg_en, cfg_hi);
    ilim_hi = ilim_is_high(adv);
    armed   = (adv == ADV_HIGH);
  end
endmodule

// File: rtl/ld_compare.sv
module ld_compare #(
  parameter int IW      = 13,
  parameter int THR_MA  = 1950,
  parameter int HYST_MA = 50
) (
  input  logic [IW-1:0] sample,
  input  logic          held,
  output logic          over
);
  localparam int REL_MA = THR_MA - HYST_MA;
  localparam logic [IW-1:0] ASSERT_LVL  = IW'(THR_MA);
  localparam logic [IW-1:0] RELEASE_LVL = IW'(REL_MA);

  // Threshold moves down by the band once the flag is held
  always_comb begin
    if (held) over = (sample > RELEASE_LVL);
    else      over = (sample > ASSERT_LVL);
  end
endmodule

// File: rtl/ld_deglitch.sv
module ld_deglitch #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic smp_vld,
  input  logic over,
  output logic state,
  output logic flip
);
  localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB - 1);

  logic [CW-1:0] cnt_q;
  logic          disagree;

  assign disagree = smp_vld && (over != state);
  assign flip     = armed && disagree && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 1'b0;
      cnt_q <= '0;
    end else if (!armed) begin
      state <= 1'b0;
      cnt_q <= '0;
    end else if (smp_vld) begin
      if (flip) begin
        state <= over;
        cnt_q <= '0;
      end else if (disagree) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/chg_adv_ldet.sv
module chg_adv_ldet
  import chg_adv_pkg::*;
#(
  parameter int IW      = 13,
  parameter int THR_MA  = 1950,
  parameter int HYST_MA = 50,
  parameter int DEB     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_hi,
  input  logic [IW-1:0] i_ma,
  input  logic          i_vld,
  output logic [1:0]    adv_code,
  output logic          ilim_sel,
  output logic          ld_n
);
  adv_t adv_w;
  logic armed_w;
  logic over_w;
  logic flip_w;
  logic state_w;

  chg_adv_decode u_dec (
    .cfg_en (cfg_en),
    .cfg_hi (cfg_hi),
    .adv    (adv_w),
    .ilim_hi(ilim_sel),
    .armed  (armed_w)
  );

  ld_compare #(.IW(IW), .THR_MA(THR_MA), .HYST_MA(HYST_MA)) u_cmp (
    .sample(i_ma),
    .held  (state_w),
    .over  (over_w)
  );

  ld_deglitch #(.DEB(DEB)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (armed_w),
    .smp_vld(i_vld),
    .over   (over_w),
    .state  (state_w),
    .flip   (flip_w)
  );

  assign adv_code = adv_w;
  assign ld_n     = ~state_w;
endmodule

// File: rtl/chg_adv_ldet_chk.sv
module chg_adv_ldet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       cfg_hi,
  input logic       i_vld,
  input logic [1:0] adv_code,
  input logic       ilim_sel,
  input logic       ld_n,
  input logic       armed_w,
  input logic       over_w,
  input logic       flip_w
);
  p_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> adv_code == 2'b00);

  p_levels_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> adv_code == (cfg_hi ? 2'b10 : 2'b01));

  p_ilim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_sel == (adv_code == 2'b10));

  p_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && cfg_hi) |=> ld_n);

  p_assert_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_n) |-> $past(armed_w && i_vld && over_w && flip_w));

  p_release_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_n) |-> $past(!armed_w || (i_vld && !over_w)));

  p_hold_novld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && !i_vld) |=> $stable(ld_n));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r9: assert (ld_n);
    end
  end
endmodule

bind chg_adv_ldet chg_adv_ldet_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_en  (cfg_en),
  .cfg_hi  (cfg_hi),
  .i_vld   (i_vld),
  .adv_code(adv_code),
  .ilim_sel(ilim_sel),
  .ld_n    (ld_n),
  .armed_w (armed_w),
  .over_w  (over_w),
  .flip_w  (flip_w)
);

// File: tb/chg_adv_ldet_test.sv
`timescale 1ns/1ps
module chg_adv_ldet_test;
  localparam int IW = 13, THR = 1950, HYS = 50, DEB = 4;

  logic clk = 0, rst_n = 0;
  logic en = 0, hi = 0, vld = 0;
  logic [IW-1:0] ma = '0;
  logic [1:0] adv;
  logic ilim, ldn;

  int errors = 0, checks = 0;
  bit mst = 0;
  int mcnt = 0;

  always #5 clk = ~clk;

  chg_adv_ldet #(.IW(IW), .THR_MA(THR), .HYST_MA(HYS), .DEB(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(en), .cfg_hi(hi), .i_ma(ma), .i_vld(vld),
    .adv_code(adv), .ilim_sel(ilim), .ld_n(ldn));

  // Cross-wired pair
  logic [IW-1:0] ma_a = '0, ma_b = '0;
  logic vld_p = 0;
  logic [1:0] adv_a, adv_b;
  logic ilim_a, ilim_b, ldn_a, ldn_b;
  chg_adv_ldet #(.IW(IW), .THR_MA(THR), .HYST_MA(HYS), .DEB(DEB)) uut_a (
    .clk(clk), .rst_n(rst_n), .cfg_en(1'b1), .cfg_hi(ldn_b), .i_ma(ma_a), .i_vld(vld_p),
    .adv_code(adv_a), .ilim_sel(ilim_a), .ld_n(ldn_a));
  chg_adv_ldet #(.IW(IW), .THR_MA(THR), .HYST_MA(HYS), .DEB(DEB)) uut_b (
    .clk(clk), .rst_n(rst_n), .cfg_en(1'b1), .cfg_hi(ldn_a), .i_ma(ma_b), .i_vld(vld_p),
    .adv_code(adv_b), .ilim_sel(ilim_b), .ld_n(ldn_b));

  function automatic logic [1:0] exp_adv(bit e, bit h);
    return !e ? 2'd0 : (h ? 2'd2 : 2'd1);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // One cycle: check flag, drive, check decode, advance model
  task automatic step(bit e, bit h, int cur, bit v, string req);
    check(ldn == !mst, req, ldn, !mst);
    en = e; hi = h; ma = IW'(cur); vld = v;
    #1;
    check(adv == exp_adv(e, h), "R1/R2 adv", adv, exp_adv(e, h));
    check(ilim == (e && h), "R3 ilim", ilim, (e && h));
    if (!(e && h)) begin
      mst = 0; mcnt = 0;
    end else if (v) begin
      bit ov;
      ov = mst ? (cur > THR - HYS) : (cur > THR);
      if (ov != mst) begin
        mcnt++;
        if (mcnt == DEB) begin mst = ov; mcnt = 0; end
      end else mcnt = 0;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pstep(int a, int b);
    ma_a = IW'(a); ma_b = IW'(b); vld_p = 1;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ldn == 1, "R9 reset ld_n", ldn, 1);
    rst_n = 1;
    @(negedge clk);
    check(ldn == 1, "R9 after reset", ldn, 1);

    // Decode sweep (R1 R2 R3)
    step(0, 0, 100, 1, "R1");
    step(0, 1, 100, 1, "R1");
    step(1, 0, 100, 1, "R2");
    step(1, 1, 100, 1, "R2");

    // Exactly at threshold: not over (R5)
    repeat (DEB + 1) step(1, 1, THR, 1, "R5 at thr");
    // One above: asserts after DEB samples (R5 R7)
    repeat (DEB) step(1, 1, THR + 1, 1, "R5 above thr");
    check(ldn == 0, "R7 asserted", ldn, 0);
    // In band: stays active (R6)
    repeat (DEB + 2) step(1, 1, THR - HYS + 1, 1, "R6 in band");
    check(ldn == 0, "R6 held", ldn, 0);
    // DEB-1 low samples then a high one restarts (R7)
    repeat (DEB - 1) step(1, 1, THR - HYS, 1, "R7 partial");
    step(1, 1, 2500, 1, "R7 restart");
    repeat (DEB - 1) step(1, 1, THR - HYS, 1, "R7 partial2");
    // Gaps do not reset count (R8)
    repeat (3) step(1, 1, 0, 0, "R8 gap");
    check(ldn == 0, "R8 held gap", ldn, 0);
    step(1, 1, THR - HYS, 1, "R6 release");
    check(ldn == 1, "R6 released", ldn, 1);
    // Disarm while active (R4)
    repeat (DEB) step(1, 1, 3000, 1, "R4 arm");
    check(ldn == 0, "R4 active", ldn, 0);
    step(1, 0, 3000, 1, "R4 disarm");
    check(ldn == 1, "R4 forced off", ldn, 1);
    repeat (DEB) step(0, 1, 3000, 1, "R4 default mode");
    check(ldn == 1, "R4 stays off", ldn, 1);

    // Random around the band
    for (int i = 0; i < 3000; i++) begin
      bit e, h, v;
      int c;
      e = ($urandom % 16) != 0;
      h = ($urandom % 16) != 0;
      v = ($urandom % 4) != 0;
      c = 1850 + int'($urandom % 200);
      if (($urandom % 8) == 0) c = int'($urandom % 4000);
      step(e, h, c, v, "R7 random");
    end
    step(0, 0, 0, 0, "R4 idle");
    @(negedge clk);

    // Cross-wired pair (R10)
    check(adv_a == 2 && adv_b == 2, "R10 both high", {adv_a, adv_b}, 4'b1010);
    repeat (DEB) pstep(2500, 500);
    check(ldn_a == 0, "R10 A flag", ldn_a, 0);
    check(adv_b == 1, "R10 B demoted", adv_b, 1);
    check(ilim_b == 0, "R10 B low limit", ilim_b, 0);
    repeat (DEB + 1) pstep(2500, 2500);
    check(ldn_b == 1, "R10 B no flag", ldn_b, 1);
    check(adv_a == 2, "R10 A stays high", adv_a, 2);
    repeat (DEB) pstep(1000, 500);
    check(ldn_a == 1, "R10 A cleared", ldn_a, 1);
    check(adv_b == 2, "R10 B restored", adv_b, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule